// File: doc/BRIEF.md
# Rank Burst Sequencer

This block sits on the controller side of one DRAM rank. The rank is a group of byte-wide chips that share a single command and address bus and one chip-select line, so every command reaches all chips together. A client hands the block one 64-byte cache-block request through a valid/ready handshake. The block splits the address into bank, row and starting column. It opens the row, streams eight column commands on consecutive columns, and moves eight bytes per beat, one byte lane per chip. It then closes the bank with a precharge and pulses a done flag. A read returns the gathered block with that pulse.

Each row leaks charge, so the block also keeps a refresh pointer that walks every row address in turn. It issues one row refresh per interval. The interval is the programmed retention window divided by the number of rows. A refresh that has come due goes ahead of the next request, but it never breaks into an access that is already running. Three programmable gaps set how long the block waits after an activate, after the last column command and after a precharge. No command is issued before its gap has run out.

Top module: `rank_burst_seq`

## Requirements
- R1: While reset is held and in the cycle after it, cmd_code is NOP (0), cmd_cs_n is high, dq_oe is low, resp_done is low and req_ready is high.
- R2: The beat address is split with the column in bits [COL_W-1:0], the bank in the next BANK_W bits and the row in the top ROW_W bits. After a request is accepted, an activate (code 1) carries that bank on cmd_bank and that row on cmd_addr. Every command other than NOP is driven with cmd_cs_n low.
- R3: An access issues exactly BEATS column commands (read code 2, write code 3) on consecutive cycles to the same bank. Command i uses column (start column + i) modulo 2^COL_W.
- R4: In beat i, byte lane c (dq bits [8c+7:8c]) carries block byte i*CHIPS+c, and block byte j sits at bits [8j+7:8j] of the block bus. dq_oe is high only in write beats. A read beat takes dq_in in the cycle of its read command.
- R5: The first column command comes exactly max(cfg_trcd,1) cycles after the activate.
- R6: The precharge (code 4) comes exactly max(cfg_twr,1) cycles after the last column command.
- R7: An activate or refresh comes at least max(cfg_trp,1) cycles after the preceding precharge or refresh.
- R8: resp_done is a one-cycle pulse in the precharge cycle of each access. At that time resp_rdata holds the block that a read gathered.
- R9: With the rank otherwise idle, refresh commands come exactly cfg_retention >> ROW_W cycles apart. A quotient of zero disables refresh.
- R10: Refresh commands (code 5) carry row numbers 0, 1, 2, ... on cmd_addr and wrap from 2^ROW_W-1 back to 0.
- R11: While a refresh is pending, req_ready stays low and the refresh is issued before any further activate. A refresh that comes due during an access waits until that access has precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 8 | Activate-to-column gap in cycles |
| cfg_twr | input | 8 | Last-column-to-precharge gap in cycles |
| cfg_trp | input | 8 | Precharge-to-activate/refresh gap in cycles |
| cfg_retention | input | 32 | Retention window in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_beat_addr | input | COL_W+BANK_W+ROW_W | Physical address bits above the byte-in-beat offset |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 512 | Block to write, byte j at bits [8j+7:8j] |
| resp_done | output | 1 | Access finished (one cycle) |
| resp_rdata | output | 512 | Gathered read block |
| cmd_cs_n | output | 1 | Rank chip-select, active low |
| cmd_code | output | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF |
| cmd_bank | output | BANK_W | Bank for the command |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column for the command |
| dq_out | output | 64 | Write beat data, lane c for chip c |
| dq_oe | output | 1 | Write data drive enable |
| dq_in | input | 64 | Read beat data from the chips |

## Verification
The assertions assume that the three gap settings and the retention window do not change while an access or a refresh wait is in progress. A change there would make the gap counters in the checker compare against a value that the sequencer never used. They also assume that the refresh interval is longer than one full access, so that at most one refresh comes due per access. The bench changes its settings only after ten or more idle cycles. In its busy phase it uses an interval of twenty cycles, which is longer than one access at the gaps it programs. It holds each request stable until it is accepted.

// File: rtl/rank_seq_pkg.sv
package rank_seq_pkg;
  localparam int DLY_W = 8;
  localparam int RET_W = 32;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dram_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_COL, ST_PRE, ST_REF, ST_WAIT
  } seq_state_e;

  // A programmed gap of zero behaves as a gap of one cycle.
  function automatic logic [DLY_W-1:0] at_least_one(input logic [DLY_W-1:0] d);
    return (d == '0) ? DLY_W'(1) : d;
  endfunction

  // Gaps of one cycle go straight to the target state.
  function automatic logic gap_is_short(input logic [DLY_W-1:0] d);
    return d <= DLY_W'(1);
  endfunction

  // Counter preload for the wait state: the launch cycle and the exit cycle
  // each account for one cycle of the gap.
  function automatic logic [DLY_W-1:0] wait_load(input logic [DLY_W-1:0] d);
    return d - DLY_W'(2);
  endfunction

  function automatic logic [RET_W-1:0] refresh_interval(input logic [RET_W-1:0] ret,
                                                        input int unsigned row_bits);
    return ret >> row_bits;
  endfunction
endpackage

// File: rtl/rank_addr_split.sv
module rank_addr_split #(
  parameter int COL_W  = 11,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int BA_W  = COL_W + BANK_W + ROW_W
) (
  input  logic [BA_W-1:0]   beat_addr,
  output logic [COL_W-1:0]  col,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row
);
  localparam int BANK_LSB = COL_W;
  localparam int ROW_LSB  = COL_W + BANK_W;

  assign col  = beat_addr[COL_W-1:0];
  assign bank = beat_addr[BANK_LSB +: BANK_W];
  assign row  = beat_addr[ROW_LSB +: ROW_W];
endmodule

// File: rtl/rank_refresh_sched.sv
module rank_refresh_sched
  import rank_seq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] cfg_retention,
  input  logic             ref_ack,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  logic [RET_W-1:0] refi;
  logic [RET_W-1:0] tmr;
  logic             expire;

  assign refi   = refresh_interval(cfg_retention, ROW_W);
  assign expire = (refi != '0) && (tmr >= refi - RET_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      if (refi == '0 || expire) tmr <= '0;
      else                      tmr <= tmr + RET_W'(1);
      if (expire)       ref_pend <= 1'b1;
      else if (ref_ack) ref_pend <= 1'b0;
      if (ref_ack) ref_row <= ref_row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/rank_beat_lanes.sv
module rank_beat_lanes #(
  parameter int CHIPS  = 8,
  parameter int CHIP_W = 8,
  parameter int BEATS  = 8,
  localparam int BEAT_W = CHIPS * CHIP_W,
  localparam int BLK_W  = BEAT_W * BEATS,
  localparam int BI_W   = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  wblock,
  input  logic [BI_W-1:0]   beat,
  input  logic              cap_en,
  input  logic [BEAT_W-1:0] dq_in,
  output logic [BEAT_W-1:0] dq_wr,
  output logic [BLK_W-1:0]  rblock
);
  // Scatter: chip c drives block byte beat*CHIPS+c.
  for (genvar c = 0; c < CHIPS; c++) begin : g_lane
    assign dq_wr[c*CHIP_W +: CHIP_W] = wblock[(int'(beat)*CHIPS + c)*CHIP_W +: CHIP_W];
  end

  // Gather: each beat slot latches the lanes in its own read cycle.
  for (genvar b = 0; b < BEATS; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                             rblock[b*BEAT_W +: BEAT_W] <= '0;
      else if (cap_en && beat == BI_W'(b))    rblock[b*BEAT_W +: BEAT_W] <= dq_in;
    end
  end
endmodule

// File: rtl/rank_burst_seq.sv
module rank_burst_seq
  import rank_seq_pkg::*;
#(
  parameter int ROW_W  = 14,
  parameter int BANK_W = 3,
  parameter int COL_W  = 11,
  parameter int CHIPS  = 8,
  parameter int CHIP_W = 8,
  parameter int BEATS  = 8,
  localparam int BEAT_W = CHIPS * CHIP_W,
  localparam int BLK_W  = BEAT_W * BEATS,
  localparam int BA_W   = COL_W + BANK_W + ROW_W,
  localparam int CA_W   = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int BI_W   = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  cfg_trcd,
  input  logic [DLY_W-1:0]  cfg_twr,
  input  logic [DLY_W-1:0]  cfg_trp,
  input  logic [RET_W-1:0]  cfg_retention,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BA_W-1:0]   req_beat_addr,
  input  logic              req_we,
  input  logic [BLK_W-1:0]  req_wdata,
  output logic              resp_done,
  output logic [BLK_W-1:0]  resp_rdata,
  output logic              cmd_cs_n,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [CA_W-1:0]   cmd_addr,
  output logic [BEAT_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [BEAT_W-1:0] dq_in
);
  function automatic logic [COL_W-1:0] col_of(input logic [COL_W-1:0] base,
                                              input logic [BI_W-1:0] k);
    return base + COL_W'(k);
  endfunction

  seq_state_e        st, tgt, ltgt;
  logic [DLY_W-1:0]  dly, lgap;
  logic              launch;
  logic [BI_W-1:0]   beat;
  logic [COL_W-1:0]  a_col, d_col, col_now;
  logic [BANK_W-1:0] a_bank, d_bank;
  logic [ROW_W-1:0]  a_row, d_row, ref_row;
  logic              a_we;
  logic [BLK_W-1:0]  wblk;
  logic [BEAT_W-1:0] dq_wr;
  logic              ref_pend, ref_ack, cap_en;

  // Named internal events for the checker.
  logic fsm_idle, burst_last, accept;
  assign fsm_idle   = (st == ST_IDLE);
  assign burst_last = (st == ST_COL) && (beat == BI_W'(BEATS-1));
  assign accept     = req_valid && req_ready;

  rank_addr_split #(.COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_split (
    .beat_addr(req_beat_addr), .col(d_col), .bank(d_bank), .row(d_row)
  );

  rank_refresh_sched #(.ROW_W(ROW_W)) u_refresh (
    .clk(clk), .rst_n(rst_n), .cfg_retention(cfg_retention),
    .ref_ack(ref_ack), .ref_pend(ref_pend), .ref_row(ref_row)
  );

  rank_beat_lanes #(.CHIPS(CHIPS), .CHIP_W(CHIP_W), .BEATS(BEATS)) u_lanes (
    .clk(clk), .rst_n(rst_n), .wblock(wblk), .beat(beat), .cap_en(cap_en),
    .dq_in(dq_in), .dq_wr(dq_wr), .rblock(resp_rdata)
  );

  // States that end with a programmed gap before the next state.
  always_comb begin
    launch = 1'b0;
    lgap   = '0;
    ltgt   = ST_IDLE;
    case (st)
      ST_ACT: begin launch = 1'b1; lgap = cfg_trcd; ltgt = ST_COL; end
      ST_COL: if (burst_last) begin launch = 1'b1; lgap = cfg_twr; ltgt = ST_PRE; end
      ST_PRE, ST_REF: begin launch = 1'b1; lgap = cfg_trp; ltgt = ST_IDLE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tgt    <= ST_IDLE;
      dly    <= '0;
      beat   <= '0;
      a_col  <= '0;
      a_bank <= '0;
      a_row  <= '0;
      a_we   <= 1'b0;
      wblk   <= '0;
    end else if (launch) begin
      if (st == ST_ACT) beat <= '0;
      if (gap_is_short(lgap)) begin
        st <= ltgt;
      end else begin
        st  <= ST_WAIT;
        dly <= wait_load(lgap);
        tgt <= ltgt;
      end
    end else begin
      case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            st <= ST_REF;
          end else if (req_valid) begin
            a_col  <= d_col;
            a_bank <= d_bank;
            a_row  <= d_row;
            a_we   <= req_we;
            wblk   <= req_wdata;
            st     <= ST_ACT;
          end
        end
        ST_COL:  beat <= beat + BI_W'(1);
        ST_WAIT: begin
          if (dly == '0) st <= tgt;
          else           dly <= dly - DLY_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign col_now   = col_of(a_col, beat);
  assign req_ready = fsm_idle && !ref_pend;
  assign ref_ack   = (st == ST_REF);
  assign cap_en    = (st == ST_COL) && !a_we;
  assign resp_done = (st == ST_PRE);

  always_comb begin
    cmd_code = CMD_NOP;
    cmd_bank = a_bank;
    cmd_addr = '0;
    case (st)
      ST_ACT: begin cmd_code = CMD_ACT; cmd_addr = CA_W'(a_row); end
      ST_COL: begin cmd_code = a_we ? CMD_WR : CMD_RD; cmd_addr = CA_W'(col_now); end
      ST_PRE: cmd_code = CMD_PRE;
      ST_REF: begin cmd_code = CMD_REF; cmd_bank = '0; cmd_addr = CA_W'(ref_row); end
      default: ;
    endcase
  end

  assign cmd_cs_n = (cmd_code == CMD_NOP);
  assign dq_oe    = (st == ST_COL) && a_we;
  assign dq_out   = dq_oe ? dq_wr : '0;
endmodule

// File: rtl/rank_burst_seq_chk.sv
module rank_burst_seq_chk
  import rank_seq_pkg::*;
#(
  parameter int COL_W = 11,
  parameter int CA_W  = 14,
  parameter int BEATS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_code,
  input logic [CA_W-1:0]  cmd_addr,
  input logic             dq_oe,
  input logic             resp_done,
  input logic             req_ready,
  input logic             fsm_idle,
  input logic             ref_pend,
  input logic [DLY_W-1:0] cfg_trcd,
  input logic [DLY_W-1:0] cfg_twr,
  input logic [DLY_W-1:0] cfg_trp
);
  logic        is_col, prev_col;
  logic [COL_W-1:0] prev_colad;
  logic [15:0] since_act, since_col, since_close;
  logic [7:0]  ncol;

  assign is_col = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);

  function automatic logic [15:0] bump(input logic [15:0] v);
    return (v == 16'h0 || v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_col    <= 1'b0;
      prev_colad  <= '0;
      since_act   <= '0;
      since_col   <= '0;
      since_close <= '0;
      ncol        <= '0;
    end else begin
      prev_col    <= is_col;
      prev_colad  <= cmd_addr[COL_W-1:0];
      since_act   <= (cmd_code == CMD_ACT) ? 16'd1 : bump(since_act);
      since_col   <= is_col ? 16'd1 : bump(since_col);
      since_close <= (cmd_code == CMD_PRE || cmd_code == CMD_REF) ? 16'd1 : bump(since_close);
      if (cmd_code == CMD_ACT) ncol <= '0;
      else if (is_col)         ncol <= ncol + 8'd1;
    end
  end

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && prev_col) |-> cmd_addr[COL_W-1:0] == prev_colad + COL_W'(1));

  assert_burst_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |-> ncol == 8'(BEATS));

  assert_oe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> cmd_code == CMD_WR);

  assert_first_col_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && !prev_col) |-> since_act == 16'(at_least_one(cfg_trcd)));

  assert_pre_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |-> since_col == 16'(at_least_one(cfg_twr)));

  assert_close_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == CMD_ACT || cmd_code == CMD_REF) && since_close != 16'h0)
      |-> since_close >= 16'(at_least_one(cfg_trp)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_ref_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && ref_pend) |-> !req_ready);
endmodule

bind rank_burst_seq rank_burst_seq_chk #(.COL_W(COL_W), .CA_W(CA_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .dq_oe(dq_oe),
  .resp_done(resp_done), .req_ready(req_ready), .fsm_idle(fsm_idle), .ref_pend(ref_pend),
  .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp)
);

// File: tb/rank_burst_seq_bench.sv
module rank_burst_seq_bench;
  localparam int ROWB = 4, BANKB = 2, COLB = 6;
  localparam int NROW = 16, NBANK = 4, NCOL = 64;
  localparam int BA_W = COLB + BANKB + ROWB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_trcd = 8'd3, cfg_twr = 8'd2, cfg_trp = 8'd4;
  logic [31:0] cfg_retention = 32'd0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic req_ready, resp_done, cmd_cs_n, dq_oe;
  logic [BA_W-1:0] req_beat_addr = '0;
  logic [511:0] req_wdata = '0, resp_rdata;
  logic [2:0] cmd_code;
  logic [BANKB-1:0] cmd_bank;
  logic [COLB-1:0] cmd_addr;
  logic [63:0] dq_out, dq_in;

  always #5 clk = ~clk;

  rank_burst_seq #(.ROW_W(ROWB), .BANK_W(BANKB), .COL_W(COLB)) u_rank_burst_seq (
    .clk(clk), .rst_n(rst_n), .cfg_trcd(cfg_trcd), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
    .cfg_retention(cfg_retention), .req_valid(req_valid), .req_ready(req_ready),
    .req_beat_addr(req_beat_addr), .req_we(req_we), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_rdata(resp_rdata), .cmd_cs_n(cmd_cs_n),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int idx(input int b, input int r, input int c);
    return (b * NROW + r) * NCOL + c;
  endfunction

  function automatic longint mx1(input logic [7:0] d);
    return (d == 0) ? 1 : longint'(d);
  endfunction

  function automatic logic [511:0] pattern(input int a, input int salt);
    logic [511:0] v;
    for (int j = 0; j < 64; j++) v[j*8 +: 8] = 8'((a * 37 + j * 11 + salt * 101 + 5) & 255);
    return v;
  endfunction

  // Behavioural rank: array of 64-bit beats, one open row per bank.
  logic [63:0] mem [0:NBANK*NROW*NCOL-1];
  int open_row [0:NBANK-1];
  assign dq_in = (cmd_code == 3'd2) ? mem[idx(int'(cmd_bank), open_row[cmd_bank], int'(cmd_addr))] : 64'h0;

  // Expectations for the access in flight.
  int exp_bank = 0, exp_row = 0, exp_col = 0;
  logic [511:0] exp_wblk = '0;
  longint cyc = 0, last_act = -1, last_col = -1, last_close = -1, last_ref = -1;
  int nb = 0, ref_cnt = 0, exp_ref_row = 0;
  bit idle_ref = 0;
  longint refi_exp = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_act = -1; last_col = -1; last_close = -1; last_ref = -1;
      nb = 0; exp_ref_row = 0;
    end else begin
      case (cmd_code)
        3'd1: begin
          chk(cmd_cs_n == 1'b0, "R2", "act cs_n", 512'(cmd_cs_n), 0);
          chk(int'(cmd_bank) == exp_bank, "R2", "act bank", 512'(cmd_bank), 512'(exp_bank));
          chk(int'(cmd_addr) == exp_row, "R2", "act row", 512'(cmd_addr), 512'(exp_row));
          if (last_close >= 0)
            chk(cyc - last_close >= mx1(cfg_trp), "R7", "pre->act gap",
                512'(cyc - last_close), 512'(mx1(cfg_trp)));
          open_row[cmd_bank] = int'(cmd_addr);
          last_act = cyc; nb = 0;
        end
        3'd2, 3'd3: begin
          if (nb == 0)
            chk(cyc - last_act == mx1(cfg_trcd), "R5", "act->col gap",
                512'(cyc - last_act), 512'(mx1(cfg_trcd)));
          else
            chk(cyc - last_col == 1, "R3", "consecutive beats", 512'(cyc - last_col), 1);
          chk(int'(cmd_addr) == (exp_col + nb) % NCOL && int'(cmd_bank) == exp_bank, "R3",
              "column", 512'(cmd_addr), 512'((exp_col + nb) % NCOL));
          if (cmd_code == 3'd3) begin
            chk(dq_oe && dq_out == exp_wblk[nb*64 +: 64], "R4", "write lanes",
                512'(dq_out), 512'(exp_wblk[nb*64 +: 64]));
            mem[idx(int'(cmd_bank), open_row[cmd_bank], int'(cmd_addr))] = dq_out;
          end else begin
            chk(!dq_oe, "R4", "oe in read", 512'(dq_oe), 0);
          end
          nb++; last_col = cyc;
        end
        3'd4: begin
          chk(cyc - last_col == mx1(cfg_twr), "R6", "col->pre gap",
              512'(cyc - last_col), 512'(mx1(cfg_twr)));
          chk(nb == 8, "R3", "beat count", 512'(nb), 8);
          chk(resp_done, "R8", "done at pre", 512'(resp_done), 1);
          last_close = cyc;
        end
        3'd5: begin
          chk(int'(cmd_addr) == exp_ref_row, "R10", "refresh row", 512'(cmd_addr), 512'(exp_ref_row));
          exp_ref_row = (exp_ref_row + 1) % NROW;
          if (last_close >= 0)
            chk(cyc - last_close >= mx1(cfg_trp), "R7", "close->ref gap",
                512'(cyc - last_close), 512'(mx1(cfg_trp)));
          if (idle_ref && last_ref >= 0)
            chk(cyc - last_ref == refi_exp, "R9", "refresh spacing",
                512'(cyc - last_ref), 512'(refi_exp));
          last_ref = cyc; ref_cnt++; last_close = cyc;
        end
        default: begin
          chk(cmd_cs_n && !resp_done, "R8", "idle cycle quiet",
              512'({cmd_cs_n, resp_done}), 512'(2'b10));
        end
      endcase
    end
  end

  task automatic access(input int a, input bit we, input logic [511:0] wd,
                        output logic [511:0] rd);
    @(negedge clk);
    exp_col = (a >> 3) % NCOL;
    exp_bank = (a >> 9) % NBANK;
    exp_row = (a >> 11) % NROW;
    exp_wblk = wd;
    req_beat_addr = BA_W'(a >> 3);
    req_we = we;
    req_wdata = wd;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_done) @(negedge clk);
    rd = resp_rdata;
  endtask

  task automatic model_block(input int a, output logic [511:0] v);
    for (int k = 0; k < 8; k++)
      v[k*64 +: 64] = mem[idx((a >> 9) % NBANK, (a >> 11) % NROW, ((a >> 3) + k) % NCOL)];
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [511:0] rd, mv;
    int a, refs0;
    longint t0;
    for (int i = 0; i < NBANK*NROW*NCOL; i++) mem[i] = '0;
    for (int i = 0; i < NBANK; i++) open_row[i] = 0;

    repeat (3) @(negedge clk);
    chk(cmd_code == 0 && cmd_cs_n && !dq_oe && !resp_done && req_ready, "R1", "during reset",
        512'({cmd_code, cmd_cs_n, dq_oe, resp_done, req_ready}), 512'(7'b0001001));
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_code == 0 && cmd_cs_n && !dq_oe && !resp_done && req_ready, "R1", "after reset",
        512'({cmd_code, cmd_cs_n, dq_oe, resp_done, req_ready}), 512'(7'b0001001));

    // Sweep every block of every row and bank: write, then check the array at
    // the arithmetically decoded location (R2, R4).
    for (int r = 0; r < NROW; r++)
      for (int b = 0; b < NBANK; b++)
        for (int k = 0; k < 8; k++) begin
          a = (r << 11) | (b << 9) | (k << 6);
          access(a, 1'b1, pattern(a, 0), rd);
          model_block(a, mv);
          chk(mv == pattern(a, 0), "R4", "array contents after write", mv, pattern(a, 0));
        end
    // Read back the whole sweep (R8).
    for (int r = 0; r < NROW; r++)
      for (int b = 0; b < NBANK; b++)
        for (int k = 0; k < 8; k++) begin
          a = (r << 11) | (b << 9) | (k << 6);
          access(a, 1'b0, '0, rd);
          chk(rd == pattern(a, 0), "R8", "read block", rd, pattern(a, 0));
        end

    // Start column near the row end wraps around (R3).
    a = (3 << 11) | (1 << 9) | (61 << 3);
    access(a, 1'b1, pattern(a, 7), rd);
    access(a, 1'b0, '0, rd);
    chk(rd == pattern(a, 7), "R3", "wrapped burst data", rd, pattern(a, 7));
    chk(ref_cnt == 0, "R9", "refresh disabled by zero interval", 512'(ref_cnt), 0);

    // Gap settings, including zero and large values (R5, R6, R7).
    for (int s = 0; s < 4; s++) begin
      repeat (12) @(negedge clk);
      cfg_trcd = (s == 0) ? 8'd0 : (s == 1) ? 8'd1 : (s == 2) ? 8'd5 : 8'd2;
      cfg_twr  = (s == 0) ? 8'd0 : (s == 1) ? 8'd1 : (s == 2) ? 8'd3 : 8'd7;
      cfg_trp  = (s == 0) ? 8'd0 : (s == 1) ? 8'd1 : (s == 2) ? 8'd6 : 8'd2;
      a = ((s + 5) << 11) | (s << 9) | (s << 6);
      access(a, 1'b1, pattern(a, s + 1), rd);
      access(a, 1'b0, '0, rd);
      chk(rd == pattern(a, s + 1), "R5", "data under gap setting", rd, pattern(a, s + 1));
    end

    // Idle refresh sweep through all rows and a wrap (R9, R10).
    repeat (12) @(negedge clk);
    cfg_trcd = 8'd3; cfg_twr = 8'd2; cfg_trp = 8'd4;
    rst_n = 1'b0;
    cfg_retention = 32'd20 * NROW;
    refi_exp = 20;
    idle_ref = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ref_cnt = 0;
    repeat (20 * (NROW + 3) + 5) @(negedge clk);
    chk(ref_cnt >= NROW + 2, "R10", "refresh count over sweep", 512'(ref_cnt), 512'(NROW + 2));

    // Busy stream: refreshes still keep pace and slot between accesses (R11).
    idle_ref = 0;
    refs0 = ref_cnt;
    t0 = cyc;
    for (int i = 0; i < 40; i++) begin
      a = ((i % NROW) << 11) | ((i % NBANK) << 9) | ((i % 8) << 6);
      access(a, 1'b0, '0, rd);
      chk(rd == pattern(a, 0) || (a == ((3 << 11) | (1 << 9))), "R11", "read during refresh load",
          rd, pattern(a, 0));
    end
    chk(ref_cnt - refs0 >= int'((cyc - t0) / 20) - 2 && ref_cnt - refs0 <= int'((cyc - t0) / 20) + 2,
        "R11", "refreshes during stream", 512'(ref_cnt - refs0), 512'((cyc - t0) / 20));

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule